// File: doc/BRIEF.md
# Receive Character Queue with Error Status and Flow Control

This block sits after a serial receiver's character assembler and in front of a CPU read port. Each finished character arrives with three error flags: parity, framing and break. The block stores the character and its flags in a small first-in first-out queue, and the CPU pops the queue by reading the data port. The status word is combinational and has no read side effect, so the CPU can look at it as often as it likes.

There are two ways to report errors. In per-character mode the status shows the flags of the character at the head of the queue. In block mode the status shows the OR of each flag over every character queued since the last error-clear command, so software can check a whole message once, at its end.

When the queue is full, one more character waits in a single holding stage. If a further start bit arrives while that stage is occupied, overrun is flagged, and the following character replaces the waiting one. A request-to-send output can throttle the sender automatically, but only after the CPU has raised it once by hand.

Top module: `uart_rx_fifo_stat`

## Requirements
- R1: After `rst_n` goes low, `status` is 0x00, and `rts` and `irq` are low. The status layout is: bit0 ready (queue not empty), bit1 full (all DEPTH entries used), bit2 overrun, bit3 parity, bit4 framing, bit5 break, bits 7:6 zero.
- R2: Characters leave the queue in arrival order. Only a `rd_data` pulse removes the head entry. `rx_data` shows the head data while bit0 is set. Cycles without `rd_data` leave the queue and `status` unchanged.
- R3: With `cfg_block_mode` low, status bits 5:3 are the break, framing and parity flags of the head entry, and 0 when the queue is empty. The character flags are carried as `chr_brk`, `chr_frm_err` and `chr_par_err`.
- R4: With `cfg_block_mode` high, status bits 5:3 are the OR of the matching flag over every character written into the queue since the last `cmd_rst_err` or receiver reset. Pops do not clear them. `cmd_rst_err` clears them.
- R5: A character that completes while the queue is full waits in a holding stage, with no overrun flagged. It is written into the queue one cycle after an entry is freed, behind all older entries.
- R6: A `start_det` pulse while the holding stage is occupied and the queue is full sets overrun (bit2). The next character replaces the waiting one, and the queue contents stay unchanged. Overrun stays set until `cmd_rst_err`.
- R7: With `cfg_auto_rts` high and `rts` high, a `start_det` pulse while the queue is full drives `rts` low on the next edge. Once the queue has a free entry and the holding stage is empty, `rts` goes high again on the following edge.
- R8: `rts` is raised only by `cmd_rts_set`, or by the automatic reassert after an automatic negation. The automatic logic never raises it first.
- R9: While the receiver is disabled (`cmd_rx_dis`), arriving characters are ignored and queued characters stay readable. The character in the holding stage is discarded when the receiver is disabled.
- R10: `cmd_rst_rx` empties the queue and the holding stage, clears every status bit, and drives `rts` and `irq` low. It also disables reception until `cmd_rx_en`.
- R11: `irq` is high exactly when `cfg_irq_en` is high and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | Assembled character available (one-cycle pulse) |
| chr_data | input | DW | Character data |
| chr_par_err | input | 1 | Parity error flag of the character |
| chr_frm_err | input | 1 | Framing error flag of the character |
| chr_brk | input | 1 | Break flag of the character |
| start_det | input | 1 | Valid start bit detected (one-cycle pulse) |
| rd_data | input | 1 | CPU data read; pops the head entry |
| cmd_rst_err | input | 1 | Clear accumulated error bits and overrun |
| cmd_rst_rx | input | 1 | Receiver reset |
| cmd_rx_en | input | 1 | Enable reception |
| cmd_rx_dis | input | 1 | Disable reception |
| cmd_rts_set | input | 1 | Manually assert request-to-send |
| cfg_block_mode | input | 1 | Select the accumulated error view |
| cfg_auto_rts | input | 1 | Enable automatic request-to-send control |
| cfg_irq_en | input | 1 | Enable the receiver-ready interrupt |
| rx_data | output | DW | Head character data |
| status | output | 8 | Status word |
| rts | output | 1 | Request-to-send, high when asserted |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count appears at once: characters come out of `rx_data` in the wrong order, or the ready and full bits disagree with the number of characters pushed. A bad holding stage shows only when the queue drains, as a character that is missing, duplicated or replaced. A stale error accumulator shows in the first status sample after a mode switch or an error-clear command. A broken request-to-send flag shows on `rts` one or two edges after the start pulse or the pop that frees an entry.

// File: rtl/uart_rx_fifo_stat.sv
module uart_rx_fifo_stat #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic [DW-1:0] chr_data,
  input  logic          chr_par_err,
  input  logic          chr_frm_err,
  input  logic          chr_brk,
  input  logic          start_det,
  input  logic          rd_data,
  input  logic          cmd_rst_err,
  input  logic          cmd_rst_rx,
  input  logic          cmd_rx_en,
  input  logic          cmd_rx_dis,
  input  logic          cmd_rts_set,
  input  logic          cfg_block_mode,
  input  logic          cfg_auto_rts,
  input  logic          cfg_irq_en,
  output logic [DW-1:0] rx_data,
  output logic [7:0]    status,
  output logic          rts,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int EW = DW + 3;
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          rx_on, hold_v, ovr, auto_neg;
  logic [EW-1:0] hold_q;
  logic [2:0]    acc;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  wire           ready    = (cnt != '0);
  wire           space    = (cnt < FULL_CNT);
  wire           take     = chr_valid && rx_on;
  wire           drain    = hold_v && space;
  wire           push     = drain || (take && !hold_v && space);
  wire           pop      = rd_data && ready;
  wire [EW-1:0]  in_ent   = {chr_brk, chr_frm_err, chr_par_err, chr_data};
  wire [EW-1:0]  push_ent = drain ? hold_q : in_ent;
  wire [EW-1:0]  head     = mem[rptr];
  wire [2:0]     head_err = ready ? head[EW-1:DW] : 3'b000;
  wire [2:0]     errs     = cfg_block_mode ? acc : head_err;

  assign rx_data = ready ? head[DW-1:0] : '0;
  assign status  = {2'b00, errs, ovr, !space, ready};
  assign irq     = cfg_irq_en && ready;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
      rx_on <= 1'b0; hold_v <= 1'b0; hold_q <= '0;
      ovr <= 1'b0; acc <= '0; rts <= 1'b0; auto_neg <= 1'b0;
    end else if (cmd_rst_rx) begin
      wptr <= '0; rptr <= '0; cnt <= '0;
      rx_on <= 1'b0; hold_v <= 1'b0;
      ovr <= 1'b0; acc <= '0; rts <= 1'b0; auto_neg <= 1'b0;
    end else begin
      if (cmd_rx_dis)     rx_on <= 1'b0;
      else if (cmd_rx_en) rx_on <= 1'b1;

      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(pop);

      if (cmd_rx_dis) begin
        hold_v <= 1'b0;
      end else if (take && (hold_v || !space)) begin
        hold_q <= in_ent;
        hold_v <= 1'b1;
      end else if (drain) begin
        hold_v <= 1'b0;
      end

      if (cmd_rst_err)
        ovr <= 1'b0;
      else if (start_det && rx_on && hold_v && !space)
        ovr <= 1'b1;

      acc <= (cmd_rst_err ? 3'b000 : acc) | (push ? push_ent[EW-1:DW] : 3'b000);

      if (cmd_rts_set) begin
        rts <= 1'b1;
        auto_neg <= 1'b0;
      end else if (cfg_auto_rts && rts && rx_on && start_det && !space) begin
        rts <= 1'b0;
        auto_neg <= 1'b1;
      end else if (auto_neg && space && !hold_v) begin
        rts <= 1'b1;
        auto_neg <= 1'b0;
      end
    end
  end
endmodule

module uart_rx_fifo_stat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_data,
  input logic       start_det,
  input logic       cmd_rst_err,
  input logic       cmd_rst_rx,
  input logic       cmd_rts_set,
  input logic       cfg_auto_rts,
  input logic       rx_on,
  input logic [7:0] status,
  input logic       rts,
  input logic       irq
);
  a_r10_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst_rx |=> (status == 8'h00 && !rts && !irq));

  a_r2_no_silent_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !rd_data && !cmd_rst_rx) |=> status[0]);

  a_r5_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !rd_data && !cmd_rst_rx) |=> status[1]);

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !cmd_rst_err && !cmd_rst_rx) |=> status[2]);

  a_r7_rts_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_rts && rx_on && rts && start_det && status[1] && !cmd_rts_set && !cmd_rst_rx) |=> !rts);
endmodule

bind uart_rx_fifo_stat uart_rx_fifo_stat_chk u_chk (.*);

// File: tb/test_uart_rx_fifo_stat.sv
module test_uart_rx_fifo_stat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chr_valid = 0, chr_par_err = 0, chr_frm_err = 0, chr_brk = 0;
  logic [7:0] chr_data = 0;
  logic start_det = 0, rd_data = 0;
  logic cmd_rst_err = 0, cmd_rst_rx = 0, cmd_rx_en = 0, cmd_rx_dis = 0, cmd_rts_set = 0;
  logic cfg_block_mode = 0, cfg_auto_rts = 0, cfg_irq_en = 0;
  logic [7:0] rx_data, status;
  logic rts, irq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  uart_rx_fifo_stat i_uart_rx_fifo_stat (.*);

  // vector: {op[1:0], blk, flags{brk,frm,par}, data[7:0], exp_status[7:0], exp_data[7:0]}
  // op: 0 push, 1 pop, 2 error clear, 3 idle
  localparam logic [29:0] VEC [13] = '{
    {2'd0, 1'b0, 3'b000, 8'h11, 8'h01, 8'h11},
    {2'd0, 1'b0, 3'b001, 8'h22, 8'h01, 8'h11},
    {2'd1, 1'b0, 3'b000, 8'h00, 8'h09, 8'h22},
    {2'd0, 1'b1, 3'b010, 8'h33, 8'h19, 8'h22},
    {2'd2, 1'b1, 3'b000, 8'h00, 8'h01, 8'h22},
    {2'd0, 1'b1, 3'b100, 8'h44, 8'h21, 8'h22},
    {2'd1, 1'b1, 3'b000, 8'h00, 8'h21, 8'h33},
    {2'd1, 1'b0, 3'b000, 8'h00, 8'h21, 8'h44},
    {2'd1, 1'b0, 3'b000, 8'h00, 8'h00, 8'h00},
    {2'd0, 1'b0, 3'b111, 8'h55, 8'h39, 8'h55},
    {2'd3, 1'b0, 3'b000, 8'h00, 8'h39, 8'h55},
    {2'd1, 1'b1, 3'b000, 8'h00, 8'h38, 8'h00},
    {2'd2, 1'b1, 3'b000, 8'h00, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] f);
    chr_valid = 1; chr_data = d; {chr_brk, chr_frm_err, chr_par_err} = f;
    tick();
    chr_valid = 0; {chr_brk, chr_frm_err, chr_par_err} = 3'b000;
  endtask

  task automatic pop_chk(input string req, input logic [7:0] exp);
    check(req, rx_data, exp);
    rd_data = 1; tick(); rd_data = 0;
  endtask

  task automatic strobe_start();
    start_det = 1; tick(); start_det = 0;
  endtask

  task automatic restart();
    cmd_rst_rx = 1; tick(); cmd_rst_rx = 0;
    cmd_rx_en = 1; tick(); cmd_rx_en = 0;
  endtask

  task automatic fill(input logic [7:0] base);
    for (int i = 0; i < 8; i++) push(base + 8'(i), 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    check("R1 status", status, 8'h00);
    check("R1 rts", {7'd0, rts}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    // R10 reception off until enabled
    push(8'h5A, 3'b000);
    check("R10 no rx before enable", status, 8'h00);
    cmd_rx_en = 1; tick(); cmd_rx_en = 0;

    // R2 R3 R4 vector walk
    for (int k = 0; k < 13; k++) begin
      logic [29:0] v;
      v = VEC[k];
      cfg_block_mode = v[27];
      case (v[29:28])
        2'd0: push(v[23:16], v[26:24]);
        2'd1: begin rd_data = 1; tick(); rd_data = 0; end
        2'd2: begin cmd_rst_err = 1; tick(); cmd_rst_err = 0; end
        default: tick();
      endcase
      check($sformatf("R3/R4 vec%0d status", k), status, v[15:8]);
      if (v[8]) check($sformatf("R2 vec%0d data", k), rx_data, v[7:0]);
    end
    cfg_block_mode = 0;

    // R5 holding stage
    restart();
    fill(8'hA0);
    check("R1 full", status, 8'h03);
    push(8'h99, 3'b000);
    check("R5 held no overrun", status, 8'h03);
    pop_chk("R5 head", 8'hA0);
    tick();
    check("R5 held drained", status, 8'h03);
    for (int i = 1; i < 8; i++) pop_chk("R5 order", 8'hA0 + 8'(i));
    pop_chk("R5 held last", 8'h99);
    check("R5 empty", status, 8'h00);

    // R6 overrun
    restart();
    fill(8'hB0);
    push(8'h9A, 3'b000);
    strobe_start();
    check("R6 overrun set", status, 8'h07);
    push(8'h9B, 3'b000);
    for (int i = 0; i < 8; i++) pop_chk("R6 fifo unchanged", 8'hB0 + 8'(i));
    pop_chk("R6 replaced", 8'h9B);
    check("R6 sticky", status, 8'h04);
    cmd_rst_err = 1; tick(); cmd_rst_err = 0;
    check("R6 cleared", status, 8'h00);

    // R8 no automatic first assertion
    restart();
    cfg_auto_rts = 1;
    check("R8 rts low", {7'd0, rts}, 8'h00);
    fill(8'hC0);
    strobe_start();
    pop_chk("R8 pop", 8'hC0);
    tick();
    check("R8 still low", {7'd0, rts}, 8'h00);

    // R7 automatic negate / reassert
    restart();
    cmd_rts_set = 1; tick(); cmd_rts_set = 0;
    check("R8 manual set", {7'd0, rts}, 8'h01);
    fill(8'hD0);
    check("R7 high while full", {7'd0, rts}, 8'h01);
    strobe_start();
    check("R7 negated", {7'd0, rts}, 8'h00);
    pop_chk("R7 pop", 8'hD0);
    tick();
    check("R7 reasserted", {7'd0, rts}, 8'h01);
    cfg_auto_rts = 0;

    // R9 disable
    restart();
    fill(8'hE0);
    push(8'hCC, 3'b000);
    cmd_rx_dis = 1; tick(); cmd_rx_dis = 0;
    push(8'hCD, 3'b000);
    for (int i = 0; i < 8; i++) pop_chk("R9 readable", 8'hE0 + 8'(i));
    tick();
    check("R9 held lost", status, 8'h00);
    cmd_rx_en = 1; tick(); cmd_rx_en = 0;
    push(8'hCE, 3'b000);
    check("R9 reenabled data", rx_data, 8'hCE);

    // R11 interrupt
    cfg_irq_en = 1; #1;
    check("R11 irq on", {7'd0, irq}, 8'h01);
    cfg_irq_en = 0; #1;
    check("R11 irq masked", {7'd0, irq}, 8'h00);
    cfg_irq_en = 1;

    // R10 receiver reset
    cmd_rts_set = 1; tick(); cmd_rts_set = 0;
    push(8'h01, 3'b111);
    cmd_rst_rx = 1; tick(); cmd_rst_rx = 0;
    check("R10 status", status, 8'h00);
    check("R10 rts", {7'd0, rts}, 8'h00);
    check("R10 irq", {7'd0, irq}, 8'h00);
    push(8'h02, 3'b000);
    check("R10 rx off", status, 8'h00);
    cmd_rx_en = 1; tick(); cmd_rx_en = 0;
    push(8'h03, 3'b000);
    check("R10 rx back", status, 8'h01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule